// File: doc/BRIEF.md
# Virtual Access Classifier

This block decides the fate of one virtual memory access per cycle. A requester presents an address, an access kind, a privilege flag and a probe flag. In the same cycle, an external TLB presents its lookup result for that address: hit, physical page number and read/write/execute rights. The block either grants the access with a physical address or denies it with a cause code. The verdict is registered and appears exactly one cycle after the request.

Two fixed address windows bypass the lookup. Supervisor accesses in the top quarter of the address space map to themselves. User accesses in the upper half trap at once. When translation is switched off, every address maps to itself.

A denied access that is not a probe raises a trap and loads the fault-reporting registers: the faulting address, the virtual page number, and a flag that tells data-side from instruction-side faults. A probe learns the verdict and changes nothing.

Top module: `xlate_fault_unit`

## Requirements
- R1: With `mmu_on` low, a valid request is granted and `phys_addr` equals `req_addr`, whatever the TLB reports.
- R2: A supervisor request with address at or above 0xC000_0000 is granted with `phys_addr` equal to `req_addr` and the TLB result ignored. A supervisor request below that address goes through the TLB.
- R3: A user request (`req_super` low) with address at or above 0x8000_0000 is denied whatever the TLB reports. The cause is 1 when `req_kind` is 2'b10 (fetch) and 2 for any other kind.
- R4: Kind encoding is 2'b00 load, 2'b01 store, 2'b10 fetch, and 2'b11 acts as a load. On a TLB hit whose right matches the kind (read for load, write for store, execute for fetch), the request is granted. `phys_addr` is then the page number followed by the low 12 address bits.
- R5: On a TLB hit without the matching right, the request is denied with cause 3 (load), 4 (store) or 5 (fetch).
- R6: On a TLB miss, the request is denied with cause 6 for a fetch and 7 for any other kind.
- R7: A trapping fault with cause 3 to 7 loads `bad_addr` with the address, `pte_vpn` with the address shifted right by 12, and `miss_dside` with 1 for a non-fetch and 0 for a fetch.
- R8: A trapping fault with cause 1 or 2 loads `bad_addr` only; `pte_vpn` and `miss_dside` keep their values.
- R9: When `req_probe` is high, a denial leaves `trap` low and changes no fault register. A probe is granted exactly as the same request without probe would be.
- R10: Outputs are valid one cycle after `req_valid`, with exactly one of `grant` and `deny` high. `trap` equals `deny` for non-probe requests. A cycle without a request drives `grant`, `deny`, `trap`, `cause` and `phys_addr` to zero.
- R11: After reset, all outputs and fault registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| req_super | input | 1 | Supervisor privilege |
| mmu_on | input | 1 | Translation enabled |
| req_probe | input | 1 | Probe only: no trap, no register update |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_ppn | input | 20 | Physical page number from TLB |
| tlb_rd | input | 1 | Page readable |
| tlb_wr | input | 1 | Page writable |
| tlb_ex | input | 1 | Page executable |
| grant | output | 1 | Access granted |
| deny | output | 1 | Access denied |
| trap | output | 1 | Denial raises an exception |
| cause | output | 3 | Fault cause, 0 when not denied |
| phys_addr | output | 32 | Physical address, 0 when not granted |
| bad_addr | output | 32 | Last trapping fault address |
| pte_vpn | output | 20 | Page number of last TLB-class trap |
| miss_dside | output | 1 | Last TLB-class trap was data-side |

## Verification
Several properties hold on every cycle:
- the one-cycle verdict with exactly one of grant and deny;
- the quiet idle cycle;
- identity mapping with translation off;
- the user upper-half trap and its cause;
- the miss causes;
- fault registers frozen on probes;
- page number and side flag frozen on supervisor-address faults.

The bench's scenarios are needed for the rest. Only they show the exact physical address formed on a hit, the permission cause chosen for each kind, and that the supervisor window ignores a denying TLB. They also show that a supervisor access just below the window does use the TLB, and the exact values loaded into the fault registers.

// File: rtl/xlate_fault_unit.sv
module xlate_fault_unit #(
  parameter int AW = 32,
  parameter int PAGE_BITS = 12,
  parameter logic [AW-1:0] BYPASS_BASE = 32'hC000_0000,
  parameter logic [AW-1:0] USER_LIMIT  = 32'h8000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  input  logic [1:0]          req_kind,
  input  logic                req_super,
  input  logic                mmu_on,
  input  logic                req_probe,
  input  logic                tlb_hit,
  input  logic [AW-PAGE_BITS-1:0] tlb_ppn,
  input  logic                tlb_rd,
  input  logic                tlb_wr,
  input  logic                tlb_ex,
  output logic                grant,
  output logic                deny,
  output logic                trap,
  output logic [2:0]          cause,
  output logic [AW-1:0]       phys_addr,
  output logic [AW-1:0]       bad_addr,
  output logic [AW-PAGE_BITS-1:0] pte_vpn,
  output logic                miss_dside
);
  localparam logic [2:0] C_NONE = 3'd0, C_SUPER_I = 3'd1, C_SUPER_D = 3'd2,
                         C_PERM_R = 3'd3, C_PERM_W = 3'd4, C_PERM_X = 3'd5,
                         C_MISS_I = 3'd6, C_MISS_D = 3'd7;

  wire is_fetch = (req_kind == 2'b10);
  wire is_store = (req_kind == 2'b01);
  wire bypass   = !mmu_on || (req_super && req_addr >= BYPASS_BASE);
  wire user_bad = !req_super && req_addr >= USER_LIMIT;
  wire right_ok = is_fetch ? tlb_ex : (is_store ? tlb_wr : tlb_rd);

  logic [2:0]    nx_cause;
  logic [AW-1:0] nx_pa;

  always_comb begin
    nx_cause = C_NONE;
    nx_pa    = '0;
    if (bypass)
      nx_pa = req_addr;
    else if (user_bad)
      nx_cause = is_fetch ? C_SUPER_I : C_SUPER_D;
    else if (!tlb_hit)
      nx_cause = is_fetch ? C_MISS_I : C_MISS_D;
    else if (!right_ok)
      nx_cause = is_fetch ? C_PERM_X : (is_store ? C_PERM_W : C_PERM_R);
    else
      nx_pa = {tlb_ppn, req_addr[PAGE_BITS-1:0]};
  end

  wire nx_deny  = req_valid && (nx_cause != C_NONE);
  wire nx_trap  = nx_deny && !req_probe;
  wire tlb_kind = (nx_cause >= C_PERM_R);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant      <= 1'b0;
      deny       <= 1'b0;
      trap       <= 1'b0;
      cause      <= C_NONE;
      phys_addr  <= '0;
      bad_addr   <= '0;
      pte_vpn    <= '0;
      miss_dside <= 1'b0;
    end else begin
      grant     <= req_valid && (nx_cause == C_NONE);
      deny      <= nx_deny;
      trap      <= nx_trap;
      cause     <= req_valid ? nx_cause : C_NONE;
      phys_addr <= req_valid ? nx_pa : '0;
      if (nx_trap) begin
        bad_addr <= req_addr;
        if (tlb_kind) begin
          pte_vpn    <= req_addr[AW-1:PAGE_BITS];
          miss_dside <= !is_fetch;
        end
      end
    end
  end
endmodule

// File: rtl/xlate_fault_unit_chk.sv
module xlate_fault_unit_chk #(
  parameter int AW = 32,
  parameter int PAGE_BITS = 12,
  parameter logic [AW-1:0] BYPASS_BASE = 32'hC000_0000,
  parameter logic [AW-1:0] USER_LIMIT  = 32'h8000_0000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [AW-1:0]           req_addr,
  input logic [1:0]              req_kind,
  input logic                    req_super,
  input logic                    mmu_on,
  input logic                    req_probe,
  input logic                    tlb_hit,
  input logic                    grant,
  input logic                    deny,
  input logic                    trap,
  input logic [2:0]              cause,
  input logic [AW-1:0]           phys_addr,
  input logic [AW-1:0]           bad_addr,
  input logic [AW-PAGE_BITS-1:0] pte_vpn,
  input logic                    miss_dside
);
  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant ^ deny));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !deny && !trap && cause == 3'd0));
  // R10
  trap_needs_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> deny);
  // R9
  probe_no_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_probe) |=> (!trap && $stable(bad_addr) && $stable(pte_vpn) && $stable(miss_dside)));
  // R1
  nommu_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mmu_on) |=> (grant && phys_addr == $past(req_addr)));
  // R3
  user_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mmu_on && !req_super && req_addr >= USER_LIMIT)
    |=> (deny && cause == (($past(req_kind) == 2'b10) ? 3'd1 : 3'd2)));
  // R6
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mmu_on && !tlb_hit && (req_super ? req_addr < BYPASS_BASE : req_addr < USER_LIMIT))
    |=> (deny && cause == (($past(req_kind) == 2'b10) ? 3'd6 : 3'd7)));
  // R8
  superaddr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && (cause == 3'd1 || cause == 3'd2)) |-> ($stable(pte_vpn) && $stable(miss_dside)));
endmodule

bind xlate_fault_unit xlate_fault_unit_chk #(
  .AW(AW), .PAGE_BITS(PAGE_BITS), .BYPASS_BASE(BYPASS_BASE), .USER_LIMIT(USER_LIMIT)
) u_chk (.*);

// File: tb/tb_xlate_fault_unit.sv
`timescale 1ns/1ps
module tb_xlate_fault_unit;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_super, mmu_on, req_probe, tlb_hit, tlb_rd, tlb_wr, tlb_ex;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic [19:0] tlb_ppn;
  logic grant, deny, trap, miss_dside;
  logic [2:0] cause;
  logic [31:0] phys_addr, bad_addr;
  logic [19:0] pte_vpn;

  xlate_fault_unit dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R11";

  logic e_grant = 0, e_deny = 0, e_trap = 0, e_dside = 0;
  logic [2:0]  e_cause = 0;
  logic [31:0] e_pa = 0, e_bad = 0;
  logic [19:0] e_vpn = 0;

  task automatic compare();
    checks++;
    if ({grant, deny, trap, cause, phys_addr, bad_addr, pte_vpn, miss_dside} !==
        {e_grant, e_deny, e_trap, e_cause, e_pa, e_bad, e_vpn, e_dside}) begin
      fails++;
      $display("FAIL %s: got g%b d%b t%b c%0d pa%h bad%h vpn%h ds%b exp g%b d%b t%b c%0d pa%h bad%h vpn%h ds%b",
        cur_tag, grant, deny, trap, cause, phys_addr, bad_addr, pte_vpn, miss_dside,
        e_grant, e_deny, e_trap, e_cause, e_pa, e_bad, e_vpn, e_dside);
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [31:0] a, input logic [1:0] k,
                      input bit sup, input bit mmu, input bit prb, input bit hit,
                      input logic [19:0] ppn, input bit r, input bit w, input bit x);
    int c;
    bit fetch;
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; req_kind = k; req_super = sup; mmu_on = mmu;
    req_probe = prb; tlb_hit = hit; tlb_ppn = ppn; tlb_rd = r; tlb_wr = w; tlb_ex = x;
    fetch = (k == 2);
    c = 0;
    e_pa = 0;
    if (v) begin
      if (!mmu || (sup && a >= 32'hC000_0000)) e_pa = a;
      else if (!sup && a >= 32'h8000_0000) c = fetch ? 1 : 2;
      else if (!hit) c = fetch ? 6 : 7;
      else if ((fetch && x) || (k == 1 && w) || ((k == 0 || k == 3) && r))
        e_pa = (32'(ppn) << 12) + (a % 4096);
      else c = fetch ? 5 : (k == 1 ? 4 : 3);
    end
    e_grant = v && c == 0;
    e_deny  = v && c != 0;
    e_trap  = e_deny && !prb;
    e_cause = 3'(c);
    if (e_trap) begin
      e_bad = a;
      if (c >= 3) begin e_vpn = 20'(a / 4096); e_dside = !fetch; end
    end
    cur_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 32'h0, 2'b00, 0, 1, 0, 0, 20'h0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 1; req_addr = 32'hFFFF_FFFF; req_kind = 2; req_super = 0;
    mmu_on = 1; req_probe = 0; tlb_hit = 0; tlb_ppn = 0; tlb_rd = 0; tlb_wr = 0; tlb_ex = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; req_valid = 0;
    // R11 reset state compared in the first step
    idle("R11");
    // R1 no translation: identity even with TLB miss, user high address
    step("R1", 1, 32'h9234_5678, 2'b01, 0, 0, 0, 0, 20'h0, 0, 0, 0);
    step("R1", 1, 32'h0000_0ABC, 2'b10, 0, 0, 0, 1, 20'hAAAAA, 0, 0, 0);
    // R2 supervisor window bypass ignores denying TLB
    step("R2", 1, 32'hC000_0000, 2'b01, 1, 1, 0, 0, 20'h0, 0, 0, 0);
    step("R2", 1, 32'hFFFF_F123, 2'b10, 1, 1, 0, 1, 20'h11111, 0, 0, 0);
    // R2 supervisor just below window uses TLB
    step("R2", 1, 32'hBFFF_F123, 2'b00, 1, 1, 0, 1, 20'h12345, 1, 0, 0);
    step("R2", 1, 32'hBFFF_F000, 2'b00, 1, 1, 0, 0, 20'h0, 1, 1, 1);
    // R3 user upper half
    step("R3", 1, 32'h8000_0000, 2'b10, 0, 1, 0, 1, 20'h1, 1, 1, 1);
    step("R3 R8", 1, 32'hC123_4567, 2'b00, 0, 1, 0, 1, 20'h1, 1, 1, 1);
    step("R3", 1, 32'h8FFF_0004, 2'b01, 0, 1, 0, 0, 20'h0, 0, 0, 0);
    // R4 grants with matching right
    step("R4", 1, 32'h0040_1FFC, 2'b00, 0, 1, 0, 1, 20'hABCDE, 1, 0, 0);
    step("R4", 1, 32'h7FFF_F001, 2'b01, 0, 1, 0, 1, 20'h00001, 0, 1, 0);
    step("R4", 1, 32'h0000_0800, 2'b10, 0, 1, 0, 1, 20'hFFFFF, 0, 0, 1);
    step("R4", 1, 32'h0000_3333, 2'b11, 0, 1, 0, 1, 20'h54321, 1, 0, 0);
    // R5 permission faults
    step("R5 R7", 1, 32'h1234_5678, 2'b00, 0, 1, 0, 1, 20'h1, 0, 1, 1);
    step("R5 R7", 1, 32'h2345_6789, 2'b01, 0, 1, 0, 1, 20'h1, 1, 0, 1);
    step("R5 R7", 1, 32'h3456_789A, 2'b10, 0, 1, 0, 1, 20'h1, 1, 1, 0);
    step("R5", 1, 32'h0000_0010, 2'b11, 1, 1, 0, 1, 20'h1, 0, 1, 1);
    // R8 supervisor-address fault keeps VPN and side flag
    step("R8", 1, 32'hF000_0000, 2'b01, 0, 1, 0, 0, 20'h0, 0, 0, 0);
    // R6 misses
    step("R6 R7", 1, 32'h0BAD_F00D, 2'b10, 0, 1, 0, 0, 20'h0, 1, 1, 1);
    step("R6 R7", 1, 32'h7654_3210, 2'b01, 0, 1, 0, 0, 20'h0, 1, 1, 1);
    step("R6", 1, 32'h0000_1000, 2'b11, 0, 1, 0, 0, 20'h0, 1, 1, 1);
    // R9 probes
    step("R9", 1, 32'h1111_1111, 2'b00, 0, 1, 1, 0, 20'h0, 0, 0, 0);
    step("R9", 1, 32'h9999_9999, 2'b10, 0, 1, 1, 0, 20'h0, 0, 0, 0);
    step("R9", 1, 32'h2222_2222, 2'b01, 0, 1, 1, 1, 20'h3, 1, 0, 1);
    step("R9", 1, 32'h3333_3ABC, 2'b01, 0, 1, 1, 1, 20'h77777, 0, 1, 0);
    idle("R9");
    // R10 back-to-back then idle
    step("R10", 1, 32'h0000_2004, 2'b00, 0, 1, 0, 1, 20'h00042, 1, 0, 0);
    step("R10", 1, 32'h0000_5000, 2'b10, 0, 1, 0, 0, 20'h0, 0, 0, 0);
    idle("R10");
    idle("R10");
    @(negedge clk);
    compare();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule